// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the system control register file of a processor core module. It sits on a simple 32-bit bus with separate read and write strobes, a byte address and write data. Software uses it to read fixed identity and status words, to program two oscillator settings behind an unlock key, to steer the boot memory remap, to request a system reset, to keep volatile and non-volatile flag words, to read a free-running 24 MHz reference count, and to run a small local interrupt bank with separate normal and fast interrupt outputs.

A read-only memory description table of bytes sits in an address window. It reports the fitted memory size, which is fixed at build time by a parameter in megabytes. The same parameter places a size code in the SDRAM configuration word at reset. The chip-level reset logic takes the one-cycle reset request pulse, and the address decoder takes the remap bit.

Read data is registered: a read strobed at a clock edge returns its word on `rdata_o` from that edge onward, and `rdata_o` holds it until the next read. Writes take effect at the edge on which `wr_i` is high. Register positions below are word indices, which are byte address bits [ADDR_W-1:2].

Top module: `sysctl_bank`

## Requirements
- R1: After reset `rdata_o`, `rst_req_o`, `remap_o`, `irq_o` and `fiq_o` are 0. Index 0 reads 0x411A3001, index 1 reads 0, index 4 reads 0x00100000, and the register at index 9 resets to 0x00000112 and accepts full 32-bit writes.
- R2: A write to index 5 stores wdata[15:0] as the key. While the key equals 0xA05F, index 5 reads 0x0001A05F; otherwise it reads the key zero-extended.
- R3: The oscillator word (index 2, reset 0x01000048) and the auxiliary oscillator word (index 7, reset 0x0007FEFF) take a write only while the key equals 0xA05F. Otherwise the write leaves them unchanged.
- R4: A write to index 3 stores wdata bit 0 and bit 2 and ignores every other bit. Index 3 reads bit 2 and bit 0 as stored, with all other bits 0. `remap_o` equals the stored bit 2, and 1 selects RAM at address zero.
- R5: A write to index 3 with wdata bit 3 set drives `rst_req_o` high for exactly the one cycle after that edge. Bit 3 of index 3 always reads 0.
- R6: A write to index 12 ORs wdata into the flag word, a write to index 13 clears the bits set in wdata, and index 12 reads the flag word. Indices 14 and 15 do the same for the non-volatile flag word, which is read at index 14. Indices 13 and 15 read 0.
- R7: The SDRAM word at index 8 accepts full 32-bit writes and reads back what was written.
- R8: Index 10 reads a 32-bit count that is 0 after reset and increments by one, with wrap, at every clock edge on which `tick_i` is high.
- R9: With MEM_MB of at least 256, 128, 64 or 32, the SDRAM word resets to 0x00011122 ORed with 0x10, 0x0C, 0x08 or 0x04. Below 32 nothing is ORed in. Table byte 31 is 64, 32, 16, 4 or 2 to match. At the default MEM_MB of 128 this gives 0x0001112E and 32.
- R10: A read at byte address 0x100+4k, for k from 0 to 31, returns table byte k zero-extended. Bytes 0 to 30 are, in hex, 80 08 04 0B 09 01 40 00 02 A0 A0 00 00 08 00 01 0E 04 1C 01 02 20 C0 00 00 00 00 30 28 30 28. Byte addresses 0x180 to 0x1FF read 0. Writes into 0x100 to 0x1FF change nothing.
- R11: The interrupt level word has one source, a soft bit at bit 0. A write to index 20 with bit 0 set sets it, and a write to index 21 with bit 0 set clears it. Index 20 reads it, and indices 17 and 25 read the level word. IRQ enables are ORed at 18, cleared at 19 and read at 18. FIQ enables are ORed at 26, cleared at 27 and read at 26.
- R12: Index 16 reads level AND IRQ enable, and index 24 reads level AND FIQ enable. `irq_o` is 1 exactly when level AND IRQ enable is nonzero, `fiq_o` likewise for the FIQ enable, and both follow the state written at the previous edge.
- R13: Any other index (6, 11, 22, 23, 28 and above outside the table window) reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, held between reads |
| tick_i | input | 1 | 24 MHz count enable, one system cycle wide |
| remap_o | output | 1 | 1 selects RAM at address zero |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong key comparison or a missed write gate shows up as an oscillator word that differs at the very next read of index 2 or 7. A wrong enable or level bit shows up at `irq_o` or `fiq_o` in the cycle after the write that exposed it. This is why the model compares all four single-bit outputs on every clock, and compares read data in the cycle after each read. Counter faults add up over time, so index 10 is read at spaced intervals against the tick pattern. The whole table window is swept, so a misplaced byte or a wrong boundary at 0x180 is caught at the address concerned.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // word indices
  localparam int unsigned W_ID       = 0;
  localparam int unsigned W_PROC     = 1;
  localparam int unsigned W_OSC      = 2;
  localparam int unsigned W_CTRL     = 3;
  localparam int unsigned W_STAT     = 4;
  localparam int unsigned W_KEY      = 5;
  localparam int unsigned W_AUX      = 7;
  localparam int unsigned W_SDRAM    = 8;
  localparam int unsigned W_INIT     = 9;
  localparam int unsigned W_RCNT     = 10;
  localparam int unsigned W_FLG_SET  = 12;
  localparam int unsigned W_FLG_CLR  = 13;
  localparam int unsigned W_NVF_SET  = 14;
  localparam int unsigned W_NVF_CLR  = 15;
  localparam int unsigned W_IRQ_ST   = 16;
  localparam int unsigned W_IRQ_RAW  = 17;
  localparam int unsigned W_IRQ_ENS  = 18;
  localparam int unsigned W_IRQ_ENC  = 19;
  localparam int unsigned W_SOFT_SET = 20;
  localparam int unsigned W_SOFT_CLR = 21;
  localparam int unsigned W_FIQ_ST   = 24;
  localparam int unsigned W_FIQ_RAW  = 25;
  localparam int unsigned W_FIQ_ENS  = 26;
  localparam int unsigned W_FIQ_ENC  = 27;
  // table window: byte 0x100..0x17F -> words 64..95
  localparam int unsigned W_TBL_LO   = 64;
  localparam int unsigned W_TBL_HI   = 96;

  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] KEY_OPEN_RD = 32'h0001_A05F;

  typedef struct packed {
    logic irq_en_set;
    logic irq_en_clr;
    logic fiq_en_set;
    logic fiq_en_clr;
    logic soft_set;
    logic soft_clr;
  } intc_cmd_t;

  function automatic logic [31:0] size_code(int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] size_byte(int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

endpackage

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [CW-1:0] count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (tick_i) count_o <= count_o + CW'(1);
  end

  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> count_o == $past(count_o) + CW'(1));
  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

endmodule

// File: rtl/sysctl_spd_rom.sv
module sysctl_spd_rom #(
  parameter int MEM_MB = 128,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  import sysctl_pkg::*;

  localparam logic [7:0] SZ_BYTE = size_byte(MEM_MB);

  function automatic logic [7:0] entry(int unsigned i);
    case (i)
      0:  return 8'h80;  1:  return 8'h08;  2:  return 8'h04;  3:  return 8'h0B;
      4:  return 8'h09;  5:  return 8'h01;  6:  return 8'h40;  7:  return 8'h00;
      8:  return 8'h02;  9:  return 8'hA0;  10: return 8'hA0;  11: return 8'h00;
      12: return 8'h00;  13: return 8'h08;  14: return 8'h00;  15: return 8'h01;
      16: return 8'h0E;  17: return 8'h04;  18: return 8'h1C;  19: return 8'h01;
      20: return 8'h02;  21: return 8'h20;  22: return 8'hC0;  23: return 8'h00;
      27: return 8'h30;  28: return 8'h28;  29: return 8'h30;  30: return 8'h28;
      31: return SZ_BYTE;
      default: return 8'h00;
    endcase
  endfunction

  assign byte_o = entry(32'(idx_i));

  always_comb begin
    if (32'(idx_i) == 31)
      assert_size_byte_R9: assert (byte_o == SZ_BYTE);
  end

endmodule

// File: rtl/sysctl_intc.sv
module sysctl_intc #(
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  sysctl_pkg::intc_cmd_t cmd_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         level_o,
  output logic [DW-1:0]         irq_en_o,
  output logic [DW-1:0]         fiq_en_o,
  output logic                  irq_o,
  output logic                  fiq_o
);

  logic soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q   <= 1'b0;
      irq_en_o <= '0;
      fiq_en_o <= '0;
    end else begin
      if (cmd_i.soft_set && wdata_i[0]) soft_q <= 1'b1;
      if (cmd_i.soft_clr && wdata_i[0]) soft_q <= 1'b0;
      if (cmd_i.irq_en_set) irq_en_o <= irq_en_o | wdata_i;
      if (cmd_i.irq_en_clr) irq_en_o <= irq_en_o & ~wdata_i;
      if (cmd_i.fiq_en_set) fiq_en_o <= fiq_en_o | wdata_i;
      if (cmd_i.fiq_en_clr) fiq_en_o <= fiq_en_o & ~wdata_i;
    end
  end

  assign level_o = {{(DW-1){1'b0}}, soft_q};
  assign irq_o   = |(level_o & irq_en_o);
  assign fiq_o   = |(level_o & fiq_en_o);

  assert_soft_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.soft_clr && wdata_i[0] |=> !irq_o && !fiq_o);
  assert_irq_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.irq_en_clr && wdata_i[0] |=> !irq_o);
  assert_fiq_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.fiq_en_clr && wdata_i[0] |=> !fiq_o);

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank #(
  parameter int ADDR_W = 10,
  parameter int MEM_MB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  output logic              remap_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import sysctl_pkg::*;

  localparam int WORD_W    = ADDR_W - 2;
  localparam int TBL_IDX_W = 5;
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);

  logic [WORD_W-1:0] word;
  int unsigned       widx;
  logic [1:0]        unused_lsb;
  assign word       = addr_i[ADDR_W-1:2];
  assign widx       = 32'(word);
  assign unused_lsb = addr_i[1:0];

  logic [31:0] osc_q, aux_q, sdram_q, init_q, flg_q, nvf_q;
  logic [15:0] key_q;
  logic        led_q, remap_q;
  logic        unlocked;
  assign unlocked = (key_q == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      flg_q     <= '0;
      nvf_q     <= '0;
      key_q     <= '0;
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= wr_i && (widx == W_CTRL) && wdata_i[3];
      if (wr_i) begin
        case (widx)
          W_OSC:     if (unlocked) osc_q <= wdata_i;
          W_AUX:     if (unlocked) aux_q <= wdata_i;
          W_KEY:     key_q   <= wdata_i[15:0];
          W_CTRL: begin
            led_q   <= wdata_i[0];
            remap_q <= wdata_i[2];
          end
          W_SDRAM:   sdram_q <= wdata_i;
          W_INIT:    init_q  <= wdata_i;
          W_FLG_SET: flg_q   <= flg_q | wdata_i;
          W_FLG_CLR: flg_q   <= flg_q & ~wdata_i;
          W_NVF_SET: nvf_q   <= nvf_q | wdata_i;
          W_NVF_CLR: nvf_q   <= nvf_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign remap_o = remap_q;

  // interrupt bank
  intc_cmd_t   icmd;
  logic [31:0] lvl, irq_en, fiq_en;

  always_comb begin
    icmd = '0;
    if (wr_i) begin
      icmd.irq_en_set = (widx == W_IRQ_ENS);
      icmd.irq_en_clr = (widx == W_IRQ_ENC);
      icmd.fiq_en_set = (widx == W_FIQ_ENS);
      icmd.fiq_en_clr = (widx == W_FIQ_ENC);
      icmd.soft_set   = (widx == W_SOFT_SET);
      icmd.soft_clr   = (widx == W_SOFT_CLR);
    end
  end

  sysctl_intc #(.DW(32)) i_intc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (icmd),
    .wdata_i  (wdata_i),
    .level_o  (lvl),
    .irq_en_o (irq_en),
    .fiq_en_o (fiq_en),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
  );

  logic [31:0] rcnt;
  sysctl_refcnt #(.CW(32)) i_refcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .count_o (rcnt)
  );

  logic [7:0] tbl_byte;
  sysctl_spd_rom #(.MEM_MB(MEM_MB), .IDX_W(TBL_IDX_W)) i_rom (
    .idx_i  (word[TBL_IDX_W-1:0]),
    .byte_o (tbl_byte)
  );

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (widx >= W_TBL_LO && widx < W_TBL_HI) begin
      rd_val = {24'd0, tbl_byte};
    end else begin
      case (widx)
        W_ID:       rd_val = ID_WORD;
        W_OSC:      rd_val = osc_q;
        W_CTRL:     rd_val = {29'd0, remap_q, 1'b0, led_q};
        W_STAT:     rd_val = STAT_WORD;
        W_KEY:      rd_val = unlocked ? KEY_OPEN_RD : {16'd0, key_q};
        W_AUX:      rd_val = aux_q;
        W_SDRAM:    rd_val = sdram_q;
        W_INIT:     rd_val = init_q;
        W_RCNT:     rd_val = rcnt;
        W_FLG_SET:  rd_val = flg_q;
        W_NVF_SET:  rd_val = nvf_q;
        W_IRQ_ST:   rd_val = lvl & irq_en;
        W_IRQ_RAW:  rd_val = lvl;
        W_IRQ_ENS:  rd_val = irq_en;
        W_SOFT_SET: rd_val = {31'd0, lvl[0]};
        W_FIQ_ST:   rd_val = lvl & fiq_en;
        W_FIQ_RAW:  rd_val = lvl;
        W_FIQ_ENS:  rd_val = fiq_en;
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assert_osc_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (widx == W_OSC || widx == W_AUX) && !unlocked |=> $stable(osc_q) && $stable(aux_q));
  assert_remap_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && widx == W_CTRL |=> remap_o == $past(wdata_i[2]));
  assert_ctrl_bit3_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && widx == W_CTRL |=> !rdata_o[3]);
  assert_key_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && widx == W_KEY && wdata_i[15:0] == UNLOCK_KEY ##1 rd_i && widx == W_KEY
    |=> rdata_o == KEY_OPEN_RD);

endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;

  localparam int ADDR_W = 10;
  localparam int MEM_MB = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata_o;
  logic              remap_o, rst_req_o, irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysctl_bank #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) i_sysctl_bank (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .tick_i(tick), .remap_o(remap_o),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .fiq_o(fiq_o));

  // table bytes 0..31 for 128 MB (R10, R9)
  bit [7:0] tbl [32] = '{8'h80, 8'h08, 8'h04, 8'h0B, 8'h09, 8'h01, 8'h40, 8'h00,
                         8'h02, 8'hA0, 8'hA0, 8'h00, 8'h00, 8'h08, 8'h00, 8'h01,
                         8'h0E, 8'h04, 8'h1C, 8'h01, 8'h02, 8'h20, 8'hC0, 8'h00,
                         8'h00, 8'h00, 8'h00, 8'h30, 8'h28, 8'h30, 8'h28, 8'd32};

  // reference model state
  bit [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nvf, m_irqen, m_fiqen, m_cnt, m_rdata;
  bit [15:0] m_key;
  bit        m_led, m_remap, m_soft, m_rreq;
  string     m_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int unsigned i);
    if (i >= 64 && i < 128) return "R10";
    case (i)
      0, 1, 4, 9: return "R1";
      5: return "R2";
      2, 7: return "R3";
      3: return "R4/R5";
      8: return "R7";
      10: return "R8";
      12, 13, 14, 15: return "R6";
      16, 24: return "R12";
      17, 18, 20, 25, 26, 19, 21, 27: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic bit [31:0] m_read(int unsigned i);
    if (i >= 64 && i < 96) return {24'd0, tbl[i-64]};
    case (i)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return {29'd0, m_remap, 1'b0, m_led};
      4: return 32'h00100000;
      5: return (m_key == 16'hA05F) ? 32'h0001A05F : {16'd0, m_key};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      10: return m_cnt;
      12: return m_flg;
      14: return m_nvf;
      16: return {31'd0, m_soft & m_irqen[0]};
      17, 25: return {31'd0, m_soft};
      18: return m_irqen;
      20: return {31'd0, m_soft};
      24: return {31'd0, m_soft & m_fiqen[0]};
      26: return m_fiqen;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdram = 32'h0001112E;
      m_init = 32'h00000112; m_flg = 0; m_nvf = 0; m_irqen = 0; m_fiqen = 0;
      m_cnt = 0; m_rdata = 0; m_key = 0; m_led = 0; m_remap = 0; m_soft = 0; m_rreq = 0;
    end else begin
      automatic int unsigned i = int'(addr) / 4;
      if (rd) begin m_rdata = m_read(i); m_tag = tag_of(i); end
      m_rreq = wr && i == 3 && wdata[3];
      if (wr) begin
        case (i)
          2: if (m_key == 16'hA05F) m_osc = wdata;
          7: if (m_key == 16'hA05F) m_aux = wdata;
          5: m_key = wdata[15:0];
          3: begin m_led = wdata[0]; m_remap = wdata[2]; end
          8: m_sdram = wdata;
          9: m_init = wdata;
          12: m_flg |= wdata;
          13: m_flg &= ~wdata;
          14: m_nvf |= wdata;
          15: m_nvf &= ~wdata;
          18: m_irqen |= wdata;
          19: m_irqen &= ~wdata;
          26: m_fiqen |= wdata;
          27: m_fiqen &= ~wdata;
          20: if (wdata[0]) m_soft = 1;
          21: if (wdata[0]) m_soft = 0;
          default: ;
        endcase
      end
      if (tick) m_cnt++;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_tag, rdata_o, m_rdata);
      chk("R5 rst_req_o", {31'd0, rst_req_o}, {31'd0, m_rreq});
      chk("R4 remap_o", {31'd0, remap_o}, {31'd0, m_remap});
      chk("R12 irq_o", {31'd0, irq_o}, {31'd0, m_soft & m_irqen[0]});
      chk("R12 fiq_o", {31'd0, fiq_o}, {31'd0, m_soft & m_fiqen[0]});
    end
  end

  // irregular tick pattern
  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % 7;
    tick <= (tick_ph == 1 || tick_ph == 3 || tick_ph == 4);
  end

  task automatic bus(input bit r, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = ADDR_W'(a); wdata = d;
    @(posedge clk);
    #1 rd = 0; wr = 0;
  endtask

  task automatic rdw(input int a); bus(1, 0, a, 0); endtask
  task automatic wrw(input int a, input logic [31:0] d); bus(0, 1, a, d); endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #(20 * 200000);
        if (!done) begin
          failures++;
          checks++;
          $display("FAIL watchdog expired");
          $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    #35;
    // R1 reset state
    chk("R1 rdata reset", rdata_o, 0);
    chk("R1 outputs reset", {28'd0, remap_o, rst_req_o, irq_o, fiq_o}, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 12; i++) rdw(i * 4);
    // R9 directed
    rdw(8 * 4);
    @(negedge clk) chk("R9 sdram size code", rdata_o, 32'h0001112E);
    rdw(32'h17C);
    @(negedge clk) chk("R9 table byte 31", rdata_o, 32'd32);

    // R3 locked, R2 key
    wrw(2 * 4, 32'hDEADBEEF); rdw(2 * 4);
    wrw(5 * 4, 32'h1234A05F); rdw(5 * 4);
    wrw(2 * 4, 32'h0ABC0123); wrw(7 * 4, 32'h00055AA5);
    rdw(2 * 4); rdw(7 * 4);
    wrw(5 * 4, 32'h0000A05E); rdw(5 * 4);
    wrw(7 * 4, 32'hFFFFFFFF); rdw(7 * 4);

    // R4/R5 control
    wrw(3 * 4, 32'hFFFFFFFF); rdw(3 * 4);
    wrw(3 * 4, 32'h00000008); wrw(3 * 4, 32'h00000004); rdw(3 * 4);
    wrw(3 * 4, 32'h00000001); rdw(3 * 4);

    // R6 flags
    wrw(12 * 4, 32'hF0F0_1234); wrw(13 * 4, 32'h00F0_0004); rdw(12 * 4); rdw(13 * 4);
    wrw(14 * 4, 32'h8000_0001); wrw(14 * 4, 32'h0000_0100); wrw(15 * 4, 32'h0000_0001);
    rdw(14 * 4); rdw(15 * 4);

    // R7 / R1 init
    wrw(8 * 4, 32'hCAFE_F00D); rdw(8 * 4);
    wrw(9 * 4, 32'h1357_9BDF); rdw(9 * 4);

    // R10 table sweep, writes ignored
    wrw(32'h104, 32'hFFFF_FFFF); wrw(32'h184, 32'hFFFF_FFFF);
    for (int a = 32'h100; a < 32'h200; a += 4) rdw(a);

    // R11 / R12 interrupts
    for (int i = 16; i < 28; i++) rdw(i * 4);
    wrw(20 * 4, 32'h0000_0002); rdw(17 * 4);
    wrw(26 * 4, 32'h0000_0001); wrw(20 * 4, 32'h0000_0001);
    rdw(24 * 4); rdw(25 * 4); rdw(20 * 4);
    wrw(18 * 4, 32'hFFFF_0001); rdw(16 * 4); rdw(18 * 4);
    wrw(19 * 4, 32'h0000_0001); rdw(16 * 4); rdw(18 * 4);
    wrw(27 * 4, 32'h0000_0001); rdw(26 * 4);
    wrw(18 * 4, 32'h0000_0001); wrw(26 * 4, 32'h0000_0001);
    wrw(21 * 4, 32'h0000_0001); rdw(17 * 4);
    wrw(20 * 4, 32'h0000_0001); wrw(21 * 4, 32'h0000_0000); rdw(20 * 4);

    // R13 unmapped
    for (int i = 28; i < 64; i++) begin wrw(i * 4, 32'hFFFF_FFFF); rdw(i * 4); end
    wrw(6 * 4, 32'hFFFF_FFFF); wrw(11 * 4, 32'hFFFF_FFFF); wrw(22 * 4, 32'h1);
    for (int i = 0; i < 28; i++) rdw(i * 4);
    bus(1, 1, 12 * 4, 32'h0000_0008); rdw(12 * 4);

    // R8 counter over time
    for (int k = 0; k < 6; k++) begin idle(37 + k * 11); rdw(10 * 4); end

    idle(3);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule